// File: doc/BRIEF.md
# Programmable Parallel Write Strobe Sequencer

This block turns single-word write requests into timed write cycles on a 16-bit asynchronous parallel bus, such as the bus of a display controller. A request offers one data word and a register/data select bit through a valid/ready handshake. The block then drives chip select, the write strobe, the select line and the data bus through five phases in a fixed order: address setup, address hold, data setup, data hold, and a turnaround gap in which the bus is idle.

Each phase lasts a number of system clocks set by a run-time count input. The counts are captured when a request is accepted. The turnaround gap is added after every write. It is not a lower limit on the total cycle length, so one write occupies exactly the sum of the five counts. For example, the counts 0, 1, 2, 1 and 4 give an 8-clock period, which is about 67 ns at 120 MHz. Software chooses the counts so that the strobe's low time, the strobe's high time and the panel's full cycle time each meet the panel's minimum.

Top module: `wr_strobe_seq`

## Requirements
- R1: While reset is asserted and directly after it, `bus_cs_n` and `bus_wr_n` are 1, `bus_data_oe` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. After acceptance `req_ready` stays 0 until the last clock of the final non-zero phase.
- R3: With back-to-back requests, accepted writes start exactly S clocks apart, where S is the sum of the five counts. In the single-request case, `req_ready` rises in clock S-1, counting clock 0 as the one right after the accepting edge.
- R4: Counting clock 0 as the one right after the accepting edge, `bus_cs_n` is 0 for clocks 0 up to AS+AH+DS+DH-1. `bus_wr_n` is 0 only for clocks AS+AH up to AS+AH+DS-1, so the strobe rises at the start of data hold.
- R5: Any phase whose count is zero is skipped entirely and adds no clocks.
- R6: `bus_data` and `bus_rs` take the values of `req_data` and `req_rs` at acceptance. They stay stable while chip select is asserted, even if the request inputs change.
- R7: The count inputs are sampled only at acceptance. Changing them during a write does not change that write's timing.
- R8: During the turnaround phase, `bus_cs_n` and `bus_wr_n` are 1 and `bus_data_oe` is 0. Outside a write, `bus_data_oe` is 0; during the four active phases it is 1.
- R9: `bus_wr_n` is never 0 while `bus_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can accept a request |
| req_rs | input | 1 | Register/data select value for the write |
| req_data | input | DW | Data word for the write |
| addr_setup_cyc | input | CW | Address setup clocks (0 allowed) |
| addr_hold_cyc | input | CW | Address hold clocks |
| data_setup_cyc | input | CW | Data setup clocks (strobe low) |
| data_hold_cyc | input | CW | Data hold clocks |
| turn_cyc | input | CW | Idle turnaround clocks after the write |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rs | output | 1 | Register/data select to the bus |
| bus_data | output | DW | Data bus value |
| bus_data_oe | output | 1 | Data bus drive enable; 0 means released |

## Verification
On every cycle the assertions check the following: the strobe is only low inside chip select; data and select hold steady inside chip select unless a new write was just accepted; an idle cycle with no request keeps the bus quiet; and a long turnaround keeps the block busy right after acceptance. The exact phase lengths, the order of the phases, the skipping of zero phases, the isolation from count changes during a write and the back-to-back period depend on the programmed counts. Only the bench's sweep over count combinations can show these, because it compares each clock against positions computed from the sums.

// File: rtl/wr_strobe_seq.sv
module wr_strobe_seq #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_rs,
  input  logic [DW-1:0] req_data,
  input  logic [CW-1:0] addr_setup_cyc,
  input  logic [CW-1:0] addr_hold_cyc,
  input  logic [CW-1:0] data_setup_cyc,
  input  logic [CW-1:0] data_hold_cyc,
  input  logic [CW-1:0] turn_cyc,
  output logic          bus_cs_n,
  output logic          bus_wr_n,
  output logic          bus_rs,
  output logic [DW-1:0] bus_data,
  output logic          bus_data_oe
);
  localparam int NPH = 5;
  localparam logic [2:0] P_AS = 3'd0, P_AH = 3'd1, P_DS = 3'd2,
                         P_DH = 3'd3, P_TA = 3'd4, P_IDLE = 3'd5;

  logic [2:0]              ph, nxt_cont, nxt_new;
  logic [CW-1:0]           cnt;
  logic [NPH-1:0][CW-1:0]  len_q, len_in;
  logic [DW-1:0]           data_q;
  logic                    rs_q, last, accept;

  assign len_in = {turn_cyc, data_hold_cyc, data_setup_cyc, addr_hold_cyc, addr_setup_cyc};

  always_comb begin
    nxt_cont = P_IDLE;
    nxt_new  = P_IDLE;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (len_q[i] != '0 && 3'(i) > ph) nxt_cont = 3'(i);
      if (len_in[i] != '0) nxt_new = 3'(i);
    end
  end

  assign last      = (ph != P_IDLE) && (cnt == CW'(1));
  assign req_ready = (ph == P_IDLE) || (last && nxt_cont == P_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= P_IDLE;
      cnt    <= '0;
      len_q  <= '0;
      data_q <= '0;
      rs_q   <= 1'b0;
    end else if (accept) begin
      len_q  <= len_in;
      data_q <= req_data;
      rs_q   <= req_rs;
      ph     <= nxt_new;
      cnt    <= (nxt_new == P_IDLE) ? '0 : len_in[nxt_new];
    end else if (last) begin
      ph  <= nxt_cont;
      cnt <= (nxt_cont == P_IDLE) ? '0 : len_q[nxt_cont];
    end else if (ph != P_IDLE) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign bus_cs_n    = (ph > P_DH);
  assign bus_wr_n    = (ph != P_DS);
  assign bus_rs      = rs_q;
  assign bus_data    = data_q;
  assign bus_data_oe = (ph <= P_DH) && (ph != P_TA);
endmodule

// File: rtl/wr_strobe_seq_chk.sv
module wr_strobe_seq_chk #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_rs,
  input logic [DW-1:0] req_data,
  input logic [CW-1:0] addr_setup_cyc,
  input logic [CW-1:0] addr_hold_cyc,
  input logic [CW-1:0] data_setup_cyc,
  input logic [CW-1:0] data_hold_cyc,
  input logic [CW-1:0] turn_cyc,
  input logic          bus_cs_n,
  input logic          bus_wr_n,
  input logic          bus_rs,
  input logic [DW-1:0] bus_data,
  input logic          bus_data_oe
);
  a_r9_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_cs_n);

  a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n) && !$past(req_valid && req_ready))
      |-> ($stable(bus_data) && $stable(bus_rs)));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && turn_cyc >= CW'(2)) |=> !req_ready);

  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> (bus_cs_n && bus_wr_n && !bus_data_oe && req_ready));
endmodule

bind wr_strobe_seq wr_strobe_seq_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/wr_strobe_seq_bench.sv
module wr_strobe_seq_bench;
  localparam int DW = 16, CW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rs = 1'b0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] as_c = '0, ah_c = '0, ds_c = '0, dh_c = '0, ta_c = '0;
  logic req_ready, bus_cs_n, bus_wr_n, bus_rs, bus_data_oe;
  logic [DW-1:0] bus_data;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  wr_strobe_seq #(.DW(DW), .CW(CW)) u_wr_strobe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_data(req_data), .addr_setup_cyc(as_c),
    .addr_hold_cyc(ah_c), .data_setup_cyc(ds_c), .data_hold_cyc(dh_c),
    .turn_cyc(ta_c), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rs(bus_rs),
    .bus_data(bus_data), .bus_data_oe(bus_data_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_one(input int a, input int b, input int d, input int h, input int t,
                         input logic [DW-1:0] w, input logic r);
    int s, act, cs_cnt;
    logic e_cs, e_wr, e_rdy;
    s = a + b + d + h + t;
    act = a + b + d + h;
    cs_cnt = 0;
    @(negedge clk);
    as_c = CW'(a); ah_c = CW'(b); ds_c = CW'(d); dh_c = CW'(h); ta_c = CW'(t);
    req_data = w; req_rs = r; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready idle", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_data = ~w; req_rs = ~r;
    as_c = 4'd7; ah_c = 4'd7; ds_c = 4'd7; dh_c = 4'd7; ta_c = 4'd7;
    for (int c = 0; c < s + 2; c++) begin
      e_cs  = !(c < act);
      e_wr  = !(c >= a + b && c < a + b + d);
      e_rdy = (c >= s - 1);
      if (!bus_cs_n) cs_cnt++;
      chk(bus_cs_n == e_cs, "R4 cs", int'(bus_cs_n), int'(e_cs));
      chk(bus_wr_n == e_wr, (a == 0 || b == 0 || h == 0) ? "R5 wr" : "R4 wr",
          int'(bus_wr_n), int'(e_wr));
      chk(req_ready == e_rdy, "R3 ready", int'(req_ready), int'(e_rdy));
      chk(bus_data_oe == !e_cs, "R8 oe", int'(bus_data_oe), int'(!e_cs));
      chk(bus_wr_n || !bus_cs_n, "R9 strobe", int'(bus_wr_n), 1);
      if (!e_cs) begin
        chk(bus_data == w, "R6 data", int'(bus_data), int'(w));
        chk(bus_rs == r, "R6 rs", int'(bus_rs), int'(r));
      end
      @(negedge clk);
    end
    chk(cs_cnt == act, "R7 counts held", cs_cnt, act);
  endtask

  task automatic run_b2b(input int a, input int b, input int d, input int h, input int t);
    int s, cyc, prev, n;
    s = a + b + d + h + t;
    cyc = 0; prev = -1; n = 0;
    @(negedge clk);
    as_c = CW'(a); ah_c = CW'(b); ds_c = CW'(d); dh_c = CW'(h); ta_c = CW'(t);
    req_valid = 1'b1;
    while (n < 4 && cyc < 200) begin
      if (req_ready) begin
        if (prev >= 0) chk(cyc - prev == s, "R3 b2b period", cyc - prev, s);
        prev = cyc;
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(n == 4, "R3 b2b count", n, 4);
    repeat (s + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_wr_n && !bus_data_oe && req_ready, "R1 in reset",
        int'({bus_cs_n, bus_wr_n, bus_data_oe, req_ready}), 4'b1101);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && bus_wr_n && !bus_data_oe && req_ready, "R1 after reset",
        int'({bus_cs_n, bus_wr_n, bus_data_oe, req_ready}), 4'b1101);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int d = 1; d < 3; d++)
          for (int h = 0; h < 3; h++)
            for (int t = 0; t < 4; t++)
              run_one(a, b, d, h, t, DW'(16'hA5C3 ^ (a * 97 + b * 31 + d * 7 + h * 3 + t)),
                      1'((a + h + t) % 2));
    run_one(0, 1, 2, 1, 4, 16'h1234, 1'b1);
    run_one(0, 1, 4, 3, 8, 16'hBEEF, 1'b0);
    run_b2b(0, 1, 2, 1, 4);
    run_b2b(0, 1, 4, 3, 8);
    run_b2b(1, 0, 1, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule